// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is a host-side master for a successive-approximation converter with a three-wire serial port. One read is one frame: the reader drops an active-low select, runs sixteen serial clock periods, and collects sixteen bits from the data line. It then removes the zero padding around the conversion code and presents the code in parallel with a one-cycle valid strobe. The serial clock comes from the system clock. Its half period is a programmable number of system cycles, so one block can serve a fast part or a slow, low-power one.

A frame starts on a `start` pulse, or back to back while `cont_mode` is high. The reader captures either before each falling serial edge (the normal case) or on each rising edge (for slow clocks). It handles 12-bit codes, or 10-bit codes that carry two trailing pad bits. Between frames the select line stays high for a programmable quiet time. An `abort` input ends a frame early and discards its result. A flag reports any pad bit that arrives as one.

The controller has five states. The transitions are:
- IDLE→LEAD on an accepted request.
- LEAD→LOW after the setup half period.
- LOW→HIGH after each low half period.
- HIGH→LOW between periods.
- HIGH→QUIET when the sixteenth period ends.
- LEAD/LOW/HIGH→QUIET on abort.
- QUIET→IDLE when the quiet count expires.

Top module: `adc_frame_reader`

## Requirements
- R1: During reset and directly after it, `cs_n`=1, `sclk`=1, `busy`=0, `result_valid`=0, `result`=0 and `frame_err`=0.
- R2: In IDLE, a high `start` or `cont_mode` at a clock edge drives `cs_n` low from the next cycle. `busy` is high from that cycle up to the cycle before `result_valid`. A `start` that arrives while a frame or quiet time is in progress is ignored.
- R3: With H = `half_div` (0 counts as 1), `sclk` stays high for the first H cycles that `cs_n` is low. It then makes sixteen periods of H cycles low followed by H cycles high, so `cs_n` is low for exactly 33·H cycles.
- R4: With `rise_capture`=0, arrival bit 0 is sampled in the last cycle before the first `sclk` fall. Arrival bit n (n=1..15) is sampled in the last cycle before fall n+1.
- R5: With `rise_capture`=1, arrival bit k-1 is sampled in the last low cycle before rising edge k (k=1..16).
- R6: With `mode10`=0, `result` equals arrival bits 4..15, with bit 4 as the MSB. `result_valid` pulses for one cycle, in the first cycle `cs_n` is high after a completed frame.
- R7: With `mode10`=1, `result[9:0]` equals arrival bits 4..13 (bit 4 as MSB) and `result[11:10]`=0.
- R8: `frame_err` is 1 when any of arrival bits 0..3 is 1, or, with `mode10`=1, when arrival bit 14 or 15 is 1. Otherwise it is 0.
- R9: After a frame ends or is aborted, `cs_n` stays high for Q cycles plus one IDLE cycle before it can fall again, where Q = `quiet_len` and 0 counts as 1.
- R10: While `cont_mode` is high, a new frame starts at the first IDLE cycle with no `start`. After it drops, no new frame begins.
- R11: `abort` high in any frame state raises `cs_n` and holds `sclk` high from the next cycle. No `result_valid` follows, and `result` and `frame_err` keep their previous values.
- R12: `half_div`, `quiet_len`, `mode10` and `rise_capture` are taken when a frame is accepted. Changes to them during that frame do not affect its timing or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one frame (acted on in IDLE only) |
| cont_mode | input | 1 | Repeat frames back to back while high |
| abort | input | 1 | End the current frame early, discarding it |
| mode10 | input | 1 | 1: 10-bit code with two trailing pads; 0: 12-bit code |
| rise_capture | input | 1 | 1: sample on rising serial edges; 0: before falling edges |
| half_div | input | DIV_W | Serial clock half period in system cycles |
| quiet_len | input | QUIET_W | Minimum quiet cycles between frames |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame in progress |
| result_valid | output | 1 | One-cycle strobe for a new result |
| result | output | 12 | Conversion code, right-aligned |
| frame_err | output | 1 | A pad bit arrived as one |

## Verification
The reference model is driven by a behavioural converter model that shifts out a known 16-bit word. The word lags by one edge in rising-capture mode, so only the correct capture edge yields the expected code.

Stimulus patterns and what each separates:
- Alternating codes, all-ones and all-zeros words separate bit order from bit position errors.
- Words with a one in a leading pad or a trailing pad exercise each half of the error flag independently of the code.
- Half periods of 0, 1, 2, 3 and 4 separate divide-by-zero handling from off-by-one phase counts.
- A divider change in mid-frame, an abort in mid-frame, a second start while busy, and continuous mode with a measured select-high gap each target one of the control paths.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    localparam int FRAME_BITS  = 16;
    localparam int LEAD_PADS   = 4;
    localparam int CODE_BITS   = 12;
    localparam int TRAIL_PADS  = 2;
    localparam int EDGE_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_QUIET
    } rd_state_t;

    typedef struct packed {
        logic rise_cap;
        logic short_code;
    } rd_mode_t;

endpackage

// File: rtl/adcrd_span_cnt.sv
module adcrd_span_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] span,
    output logic         last
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] span_eff;

    always_comb begin
        span_eff = (span == '0) ? W'(1) : span;
        last     = run && (cnt_q == span_eff - W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/adcrd_shifter.sv
module adcrd_shifter #(
    parameter int FRAME_BITS = 16,
    parameter int LEAD_PADS  = 4,
    parameter int CODE_BITS  = 12,
    parameter int TRAIL_PADS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 shift_en,
    input  logic                 bit_in,
    input  logic                 short_code,
    output logic [CODE_BITS-1:0] code_out,
    output logic                 pad_err
);

    localparam int SHORT_BITS = CODE_BITS - TRAIL_PADS;

    logic [FRAME_BITS-1:0] sh_q;
    logic [LEAD_PADS-1:0]  lead_bits;
    logic [CODE_BITS-1:0]  full_code;
    logic [CODE_BITS-1:0]  short_val;
    logic                  trail_hit;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh_q <= '0;
        end else if (shift_en) begin
            sh_q <= {sh_q[FRAME_BITS-2:0], bit_in};
        end
    end

    assign lead_bits = sh_q[FRAME_BITS-1 -: LEAD_PADS];
    assign full_code = sh_q[CODE_BITS-1:0];

    generate
        if (TRAIL_PADS > 0) begin : g_trail
            assign short_val = {{TRAIL_PADS{1'b0}}, sh_q[CODE_BITS-1 -: SHORT_BITS]};
            assign trail_hit = |sh_q[TRAIL_PADS-1:0];
        end else begin : g_no_trail
            assign short_val = full_code;
            assign trail_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        code_out = short_code ? short_val : full_code;
        pad_err  = (|lead_bits) | (short_code & trail_hit);
    end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adcrd_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int QUIET_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cont_mode,
    input  logic                 abort,
    input  logic                 mode10,
    input  logic                 rise_capture,
    input  logic [DIV_W-1:0]     half_div,
    input  logic [QUIET_W-1:0]   quiet_len,
    input  logic                 sdata,
    output logic                 cs_n,
    output logic                 sclk,
    output logic                 busy,
    output logic                 result_valid,
    output logic [CODE_BITS-1:0] result,
    output logic                 frame_err
);

    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(FRAME_BITS);

    rd_state_t            state_q, state_d;
    logic [EDGE_W-1:0]    edge_q;
    logic [DIV_W-1:0]     div_q;
    logic [QUIET_W-1:0]   quiet_q;
    rd_mode_t             mode_q;

    logic                 in_frame;
    logic                 go;
    logic                 accept;
    logic                 phase_last;
    logic                 quiet_last;
    logic                 at_last_edge;
    logic                 frame_end;
    logic                 shift_en;
    logic [CODE_BITS-1:0] code_w;
    logic                 pad_err_w;

    assign in_frame     = (state_q == ST_LEAD) || (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign go           = start | cont_mode;
    assign accept       = (state_q == ST_IDLE) && go;
    assign at_last_edge = (edge_q == LAST_EDGE);
    assign frame_end    = (state_q == ST_HIGH) && phase_last && at_last_edge && !abort;

    always_comb begin
        shift_en = 1'b0;
        if (phase_last && !abort) begin
            unique case (state_q)
                ST_LEAD:  shift_en = !mode_q.rise_cap;
                ST_LOW:   shift_en = mode_q.rise_cap;
                ST_HIGH:  shift_en = !mode_q.rise_cap && !at_last_edge;
                default:  shift_en = 1'b0;
            endcase
        end
    end

    adcrd_span_cnt #(.W(DIV_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_frame),
        .span  (div_q),
        .last  (phase_last)
    );

    adcrd_span_cnt #(.W(QUIET_W)) u_quiet (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_QUIET),
        .span  (quiet_q),
        .last  (quiet_last)
    );

    adcrd_shifter #(
        .FRAME_BITS (FRAME_BITS),
        .LEAD_PADS  (LEAD_PADS),
        .CODE_BITS  (CODE_BITS),
        .TRAIL_PADS (TRAIL_PADS)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (state_q == ST_IDLE),
        .shift_en   (shift_en),
        .bit_in     (sdata),
        .short_code (mode_q.short_code),
        .code_out   (code_w),
        .pad_err    (pad_err_w)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (abort)           state_d = ST_QUIET;
                else if (phase_last) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (abort)           state_d = ST_QUIET;
                else if (phase_last) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (abort)           state_d = ST_QUIET;
                else if (phase_last) state_d = at_last_edge ? ST_QUIET : ST_LOW;
            end
            ST_QUIET: begin
                if (quiet_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // falling-edge counter and per-frame configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q  <= '0;
            div_q   <= DIV_W'(1);
            quiet_q <= QUIET_W'(1);
            mode_q  <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                edge_q <= '0;
            end else if (phase_last && state_q == ST_LEAD) begin
                edge_q <= EDGE_W'(1);
            end else if (phase_last && state_q == ST_HIGH && !at_last_edge) begin
                edge_q <= edge_q + EDGE_W'(1);
            end
            if (accept) begin
                div_q           <= half_div;
                quiet_q         <= quiet_len;
                mode_q.rise_cap   <= rise_capture;
                mode_q.short_code <= mode10;
            end
        end
    end

    // result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_valid <= 1'b0;
            result       <= '0;
            frame_err    <= 1'b0;
        end else begin
            result_valid <= frame_end;
            if (frame_end) begin
                result    <= code_w;
                frame_err <= pad_err_w;
            end
        end
    end

    // pin outputs decoded from state
    always_comb begin
        cs_n = !in_frame;
        sclk = (state_q != ST_LOW);
        busy = in_frame;
    end

endmodule

// File: rtl/adcrd_checker.sv
module adcrd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        sclk,
    input logic        busy,
    input logic        result_valid,
    input logic [11:0] result,
    input logic        frame_err
);

    // R6: strobe lasts one cycle
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R2: a result only follows a busy frame
    a_r2_valid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ($past(busy) && !busy));

    // R3: serial clock is high when select falls
    a_r3_lead_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> sclk);

    // R3: serial clock idles high while deselected
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R9: select never pulses high for a single cycle
    a_r9_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

    // R11: result and flag only move with the strobe
    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(result) && $stable(frame_err)));

endmodule

bind adc_frame_reader adcrd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .sclk         (sclk),
    .busy         (busy),
    .result_valid (result_valid),
    .result       (result),
    .frame_err    (frame_err)
);

// File: tb/sim_adc_frame_reader.sv
module sim_adc_frame_reader;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int QW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cont_mode = 1'b0;
    logic          abort = 1'b0;
    logic          mode10 = 1'b0;
    logic          rise_capture = 1'b0;
    logic [DW-1:0] half_div = 8'd1;
    logic [QW-1:0] quiet_len = 10'd1;
    logic          sdata = 1'b1;
    logic          cs_n, sclk, busy, result_valid, frame_err;
    logic [11:0]   result;

    int n_chk = 0;
    int n_bad = 0;

    adc_frame_reader #(.DIV_W(DW), .QUIET_W(QW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cont_mode(cont_mode),
        .abort(abort), .mode10(mode10), .rise_capture(rise_capture),
        .half_div(half_div), .quiet_len(quiet_len), .sdata(sdata),
        .cs_n(cs_n), .sclk(sclk), .busy(busy), .result_valid(result_valid),
        .result(result), .frame_err(frame_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [11:0] ref_code(input logic [15:0] w, input bit m10);
        if (m10) return {2'b00, w[11:2]};
        return w[11:0];
    endfunction

    function automatic bit ref_err(input logic [15:0] w, input bit m10);
        return (w[15:12] != 4'h0) || (m10 && (w[1:0] != 2'b00));
    endfunction

    // ---------------- reference model ----------------
    logic [15:0] frame_word = 16'h0;
    int          m_mode = 0;      // 0 idle, 1 frame, 2 quiet
    int          m_pos = 0, m_qpos = 0, m_h = 1, m_qe = 1;
    bit          m_rise = 0, m_m10 = 0;
    logic [15:0] m_word = 16'h0;
    bit          e_valid = 0;
    logic [11:0] e_result = 12'h0;
    bit          e_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_pos = 0; m_qpos = 0;
            e_valid = 0; e_result = 12'h0; e_err = 0;
        end else begin
            e_valid = 0;
            case (m_mode)
                0: if (start || cont_mode) begin
                    m_mode = 1; m_pos = 0;
                    m_h    = (half_div == 0) ? 1 : int'(half_div);
                    m_qe   = (quiet_len == 0) ? 1 : int'(quiet_len);
                    m_rise = rise_capture; m_m10 = mode10; m_word = frame_word;
                end
                1: if (abort) begin
                    m_mode = 2; m_qpos = 0;
                end else if (m_pos == 33*m_h - 1) begin
                    m_mode = 2; m_qpos = 0; e_valid = 1;
                    e_result = ref_code(m_word, m_m10);
                    e_err    = ref_err(m_word, m_m10);
                end else begin
                    m_pos++;
                end
                default: if (m_qpos == m_qe - 1) m_mode = 0; else m_qpos++;
            endcase
        end
    end

    // ---------------- compare, gap measurement, converter model ----------------
    bit cmp_on = 0;
    int falls = 0;
    bit prev_sclk = 1;
    int low_run = 0, last_low = 0, hi_run = 0, last_hi = 0, vcount = 0;

    always @(negedge clk) begin
        bit e_cs, e_sclk;
        int idx;
        e_cs   = (m_mode != 1);
        e_sclk = 1;
        if (m_mode == 1 && ((m_pos / m_h) % 2 == 1)) e_sclk = 0;
        if (cmp_on) begin
            chk(cs_n === e_cs, "R2", "cs_n", int'(cs_n), int'(e_cs));
            chk(sclk === e_sclk, "R3", "sclk", int'(sclk), int'(e_sclk));
            chk(busy === !e_cs, "R2", "busy", int'(busy), int'(!e_cs));
            chk(result_valid === e_valid, "R6", "result_valid", int'(result_valid), int'(e_valid));
            chk(result === e_result, "R6", "result", int'(result), int'(e_result));
            chk(frame_err === e_err, "R8", "frame_err", int'(frame_err), int'(e_err));
        end
        if (result_valid === 1'b1) vcount++;
        if (cs_n === 1'b0) begin
            low_run++;
            if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
        end else begin
            hi_run++;
            if (low_run > 0) begin last_low = low_run; low_run = 0; end
        end
        if (cs_n !== 1'b0) begin
            falls = 0;
            sdata = 1'b1;
        end else begin
            if (prev_sclk && !sclk) falls++;
            idx = falls - (m_rise ? 1 : 0);
            if (idx < 0) idx = 0;
            if (idx > 15) idx = 15;
            sdata = m_word[15 - idx];
        end
        prev_sclk = sclk;
    end

    // ---------------- stimulus ----------------
    task automatic wait_valid();
        while (result_valid !== 1'b1) @(negedge clk);
    endtask

    task automatic do_frame(input logic [15:0] w, input bit m10, input bit rise,
                            input int div, input int q, input logic [11:0] exp_res,
                            input bit exp_err, input string tag);
        @(negedge clk);
        frame_word = w; mode10 = m10; rise_capture = rise;
        half_div = DW'(div); quiet_len = QW'(q); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_valid();
        chk(result == exp_res, tag, "code", int'(result), int'(exp_res));
        chk(frame_err == exp_err, tag, "pad flag", int'(frame_err), int'(exp_err));
        @(negedge clk);
        chk(last_low == 33*((div == 0) ? 1 : div), "R3", "select low length",
            last_low, 33*((div == 0) ? 1 : div));
        repeat (q + 3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v0;
        logic [11:0] keep_res;
        bit keep_err;
        repeat (2) @(posedge clk);
        cmp_on = 1;
        @(negedge clk);
        // R1 reset values
        chk(cs_n === 1'b1 && sclk === 1'b1, "R1", "pins in reset", int'({cs_n, sclk}), 3);
        chk(busy === 1'b0 && result_valid === 1'b0, "R1", "status in reset",
            int'({busy, result_valid}), 0);
        chk(result === 12'h0 && frame_err === 1'b0, "R1", "result in reset", int'(result), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n === 1'b1 && busy === 1'b0, "R1", "idle after reset", int'({cs_n, busy}), 2);

        // R4 / R6 falling capture, 12-bit
        do_frame(16'h0ABC, 0, 0, 1, 1, 12'hABC, 0, "R4");
        do_frame(16'h0FFF, 0, 0, 3, 2, 12'hFFF, 0, "R6");
        do_frame(16'h0000, 0, 0, 2, 1, 12'h000, 0, "R6");
        // R7 10-bit
        do_frame(16'h0A94, 1, 0, 2, 1, 12'h2A5, 0, "R7");
        do_frame(16'h0FFC, 1, 0, 1, 1, 12'h3FF, 0, "R7");
        // R8 pad errors
        do_frame(16'h0A95, 1, 0, 1, 1, 12'h2A5, 1, "R8");
        do_frame(16'h8123, 0, 0, 1, 1, 12'h123, 1, "R8");
        do_frame(16'h0A97, 0, 0, 1, 1, 12'hA97, 0, "R8");
        // R5 rising capture
        do_frame(16'h0555, 0, 1, 4, 1, 12'h555, 0, "R5");
        do_frame(16'h0A94, 1, 1, 3, 1, 12'h2A5, 0, "R5");
        // R3 zero divider counts as one
        do_frame(16'h0321, 0, 0, 0, 0, 12'h321, 0, "R3");

        // R12 configuration change mid-frame
        @(negedge clk);
        frame_word = 16'h0123; mode10 = 0; rise_capture = 0; half_div = 8'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        half_div = 8'd7; mode10 = 1; rise_capture = 1;
        wait_valid();
        chk(result == 12'h123, "R12", "code after mid-frame change", int'(result), 'h123);
        @(negedge clk);
        chk(last_low == 66, "R12", "select low length", last_low, 66);
        mode10 = 0; rise_capture = 0; half_div = 8'd2;
        repeat (5) @(negedge clk);

        // R2 start during a frame is ignored
        v0 = vcount;
        @(negedge clk);
        frame_word = 16'h0456; quiet_len = 10'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (120) @(negedge clk);
        chk(vcount - v0 == 1, "R2", "results from double start", vcount - v0, 1);
        chk(busy === 1'b0, "R2", "idle after ignored start", int'(busy), 0);

        // R11 abort
        keep_res = result; keep_err = frame_err; v0 = vcount;
        @(negedge clk);
        frame_word = 16'h8FFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(cs_n === 1'b1 && sclk === 1'b1, "R11", "pins after abort", int'({cs_n, sclk}), 3);
        repeat (80) @(negedge clk);
        chk(vcount == v0, "R11", "strobes after abort", vcount - v0, 0);
        chk(result == keep_res && frame_err == keep_err, "R11", "held result",
            int'(result), int'(keep_res));

        // R9 / R10 continuous mode with quiet time 5
        @(negedge clk);
        frame_word = 16'h0789; half_div = 8'd1; quiet_len = 10'd5; cont_mode = 1'b1;
        wait_valid();
        @(negedge clk);
        while (cs_n !== 1'b0) @(negedge clk);
        @(negedge clk);
        chk(last_hi == 6, "R9", "select high gap", last_hi, 6);
        chk(busy === 1'b1, "R10", "restart without start", int'(busy), 1);
        cont_mode = 1'b0;
        wait_valid();
        chk(result == 12'h789, "R10", "repeated code", int'(result), 'h789);
        repeat (40) @(negedge clk);
        chk(busy === 1'b0 && cs_n === 1'b1, "R10", "stops after mode drops",
            int'({busy, cs_n}), 1);

        finish_run();
    end

endmodule